// File: doc/BRIEF.md
# Rotating XOR Output Network

This block is the last stage of a delay-based response generator built from several parallel arbiter chains. It takes the raw bit from each of `NUM_ARB` arbiters and forms an `NUM_OUT`-bit response. Each response bit is the parity of a window of `WIN` consecutive arbiter bits. The window for output bit `j` starts at an offset set by `SHIFT` and wraps around the arbiter vector, so neighbouring output bits see windows that overlap and rotate.

The tap pattern is fixed when the block is elaborated, so the parity logic is plain wiring into an XOR tree. The result goes through a single register stage. A valid flag travels alongside the data with the same one-cycle delay. The data register loads only when the input is marked valid and holds its value between valid beats. The parameters must satisfy 1 ≤ `WIN` ≤ `NUM_ARB`. An illegal combination stops elaboration.

Top module: `rot_xor_net`

## Requirements
- R1: After a cycle in which `valid_i` is 1, `resp_o[j]` equals the XOR over t = 0..WIN-1 of `arb_i[(j + t + SHIFT + 1) mod NUM_ARB]`, using 0-based bit positions for j, t and the arbiter index.
- R2: Arbiter indices wrap modulo `NUM_ARB`, so an output bit whose window runs past bit NUM_ARB-1 continues at bit 0. This also holds when `NUM_OUT` exceeds `NUM_ARB`.
- R3: When `WIN` equals `NUM_ARB`, every output bit equals the parity of all arbiter bits captured in that valid cycle.
- R4: `valid_o` equals the value `valid_i` had at the previous rising clock edge.
- R5: In a cycle with `valid_i` at 0, `resp_o` keeps its previous value whatever `arb_i` does.
- R6: While `rst_ni` is 0, `resp_o` is all zeros and `valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Marks `arb_i` as a fresh set of arbiter bits |
| arb_i | input | NUM_ARB | Individual arbiter response bits |
| valid_o | output | 1 | `valid_i` delayed by one cycle |
| resp_o | output | NUM_OUT | Registered rotated-window parity response |

## Verification
Within one cycle the block can either capture a new window parity or hold its earlier result, and both paths feed the same register. The bench provokes both paths by toggling `valid_i` every cycle while `arb_i` changes on every cycle. A capture is therefore always followed at once by a hold whose input differs. A behavioural model compares the outputs on every falling edge, and a held cycle is judged against the last captured parity and not the current input. The bench runs a second instance in which the window spans every arbiter and there are more outputs than arbiters, which exercises the wrap-around and full-parity cases.

// File: rtl/rot_xor_pkg.sv
package rot_xor_pkg;

  // 0-based arbiter position feeding tap t of output bit j
  function automatic int unsigned tap_pos(input int unsigned j,
                                          input int unsigned t,
                                          input int unsigned shift,
                                          input int unsigned n_arb);
    return (j + t + shift + 1) % n_arb;
  endfunction

endpackage

// File: rtl/rot_xor_lane.sv
module rot_xor_lane #(
  parameter int unsigned NUM_ARB = 8,
  parameter int unsigned WIN     = 3,
  parameter int unsigned SHIFT   = 2,
  parameter int unsigned LANE    = 0
) (
  input  logic [NUM_ARB-1:0] arb_i,
  output logic               bit_o
);
  import rot_xor_pkg::*;

  logic [WIN-1:0] taps;

  for (genvar t = 0; t < WIN; t++) begin : g_tap
    localparam int unsigned POS = tap_pos(LANE, t, SHIFT, NUM_ARB);
    assign taps[t] = arb_i[POS];
  end

  assign bit_o = ^taps;

endmodule

// File: rtl/rot_xor_stage.sv
module rot_xor_stage #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic [WIDTH-1:0] d_i,
  output logic             vld_o,
  output logic [WIDTH-1:0] q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      q_o   <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) q_o <= d_i;
    end
  end

endmodule

// File: rtl/rot_xor_net.sv
module rot_xor_net #(
  parameter int unsigned NUM_ARB = 8,
  parameter int unsigned NUM_OUT = 8,
  parameter int unsigned WIN     = 3,
  parameter int unsigned SHIFT   = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [NUM_ARB-1:0] arb_i,
  output logic               valid_o,
  output logic [NUM_OUT-1:0] resp_o
);

  if (WIN < 1 || WIN > NUM_ARB) begin : g_bad_win
    $error("rot_xor_net: WIN must lie in 1..NUM_ARB");
  end

  logic [NUM_OUT-1:0] par;

  for (genvar j = 0; j < NUM_OUT; j++) begin : g_lane
    rot_xor_lane #(
      .NUM_ARB(NUM_ARB),
      .WIN    (WIN),
      .SHIFT  (SHIFT),
      .LANE   (j)
    ) u_lane (
      .arb_i(arb_i),
      .bit_o(par[j])
    );
  end

  rot_xor_stage #(
    .WIDTH(NUM_OUT)
  ) u_stage (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vld_i (valid_i),
    .d_i   (par),
    .vld_o (valid_o),
    .q_o   (resp_o)
  );

endmodule

// File: rtl/rot_xor_net_chk.sv
module rot_xor_net_chk #(
  parameter int unsigned NUM_ARB = 8,
  parameter int unsigned NUM_OUT = 8,
  parameter int unsigned WIN     = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic [NUM_ARB-1:0] arb_i,
  input logic               valid_o,
  input logic [NUM_OUT-1:0] resp_o
);

  AST_VALID_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);  // R4

  AST_VALID_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);  // R4

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(resp_o));  // R5

  AST_ZERO_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && arb_i == '0) |=> (resp_o == '0));  // R1

  if (WIN == NUM_ARB) begin : g_full
    AST_FULL_PARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> (resp_o == {NUM_OUT{^$past(arb_i)}}));  // R3
  end

endmodule

bind rot_xor_net rot_xor_net_chk #(
  .NUM_ARB(NUM_ARB),
  .NUM_OUT(NUM_OUT),
  .WIN    (WIN)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .arb_i  (arb_i),
  .valid_o(valid_o),
  .resp_o (resp_o)
);

// File: tb/rot_xor_net_tb.sv
module rot_xor_net_tb;

  localparam int KA = 8, MA = 8, XA = 3, SA = 2;
  localparam int KB = 5, MB = 7, XB = 5, SB = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0;
  logic [KA-1:0] ra = '0;
  logic [KB-1:0] rb = '0;
  logic va_o, vb_o;
  logic [MA-1:0] oa;
  logic [MB-1:0] ob;

  int n_chk = 0;
  int n_bad = 0;
  bit run_chk = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  rot_xor_net #(.NUM_ARB(KA), .NUM_OUT(MA), .WIN(XA), .SHIFT(SA)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vld), .arb_i(ra),
    .valid_o(va_o), .resp_o(oa));

  rot_xor_net #(.NUM_ARB(KB), .NUM_OUT(MB), .WIN(XB), .SHIFT(SB)) u_dut_full (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vld), .arb_i(rb),
    .valid_o(vb_o), .resp_o(ob));

  // 1-based formula, result mapped to a 0-based bit position
  function automatic logic [MA-1:0] ref_a(input logic [KA-1:0] r);
    logic [MA-1:0] o = '0;
    for (int j = 1; j <= MA; j++) begin
      for (int i = 1; i <= XA; i++) begin
        int idx = (j + SA + i) % KA;
        int pos = (idx == 0) ? KA - 1 : idx - 1;
        o[j-1] = o[j-1] ^ r[pos];
      end
    end
    return o;
  endfunction

  function automatic logic [MB-1:0] ref_b(input logic [KB-1:0] r);
    logic [MB-1:0] o = '0;
    for (int j = 1; j <= MB; j++) begin
      for (int i = 1; i <= XB; i++) begin
        int idx = (j + SB + i) % KB;
        int pos = (idx == 0) ? KB - 1 : idx - 1;
        o[j-1] = o[j-1] ^ r[pos];
      end
    end
    return o;
  endfunction

  logic [MA-1:0] exp_a;
  logic [MB-1:0] exp_b;
  logic exp_v;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_a <= '0;
      exp_b <= '0;
      exp_v <= 1'b0;
    end else begin
      exp_v <= vld;
      if (vld) begin
        exp_a <= ref_a(ra);
        exp_b <= ref_b(rb);
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (run_chk) begin
      check("R4 valid_o", 32'(va_o), 32'(exp_v));
      check("R4 valid_o full", 32'(vb_o), 32'(exp_v));
      check(exp_v ? "R1 resp_o" : "R5 resp_o held", 32'(oa), 32'(exp_a));
      check(exp_v ? "R2 R3 resp_o full window" : "R5 resp_o full held",
            32'(ob), 32'(exp_b));
    end
  end

  task automatic drive(input logic v, input logic [KA-1:0] a, input logic [KB-1:0] b);
    @(negedge clk);
    vld = v;
    ra  = a;
    rb  = b;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    vld = 1'b1;
    ra  = '1;
    rb  = '1;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check("R6 reset resp_o", 32'(oa), 32'(0));
      check("R6 reset valid_o", 32'(va_o), 32'(0));
      check("R6 reset resp_o full", 32'(ob), 32'(0));
    end
    vld = 1'b0;
    rst_n = 1'b1;
    run_chk = 1'b1;

    // walking one: each arbiter bit reaches exactly its window lanes (R1, R2)
    for (int b = 0; b < KA; b++) drive(1'b1, KA'(1) << b, KB'(1) << (b % KB));
    drive(1'b1, '1, '1);
    drive(1'b1, '0, '0);
    drive(1'b1, 8'hA5, 5'h15);
    // capture / hold alternation with changing inputs (R5)
    for (int c = 0; c < 60; c++)
      drive(c[0], KA'($urandom), KB'($urandom));
    // random valid pattern
    for (int c = 0; c < 300; c++)
      drive(($urandom % 3) != 0, KA'($urandom), KB'($urandom));
    // long idle with noisy inputs (R5)
    for (int c = 0; c < 12; c++) drive(1'b0, KA'($urandom), KB'($urandom));
    drive(1'b0, '0, '0);
    @(negedge clk);
    summary();
  end

  initial begin
    #(8 * 100000);
    n_bad++;
    $display("FAIL R4 watchdog: actual hung expected finished");
    summary();
  end

endmodule